// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM alive by producing its refresh cycles and by competing for the memory bus with the normal access sequencer. An interval timer adds one refresh to a small saturating backlog each time it expires. Whenever there is backlog, the block raises a request. When the access sequencer grants the bus between its own cycles, the block runs one complete refresh cycle on the strobe and address lines. The request stays high until the backlog is empty.

Two refresh styles are offered, picked by a mode input that is sampled when each cycle starts. The first is CAS-before-RAS, where the device's own row counter is used and no address is driven. The second is RAS-only, where a row counter inside this block is put on the address lines and advances after each such cycle. The timer period follows the style and the row/column split chosen by parameter. With a 12/12 split, both styles use the base period of about 15.6 µs. With a 13/11 split, CAS-before-RAS uses twice the base period, because only 4096 rows must be covered in 128 ms. RAS-only keeps the base period, because 8192 rows must be covered.

After reset the block first issues eight warm-up refreshes back to back. It holds its busy flag high for the whole of that burst, so normal traffic waits.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied and right after it, rasN, casN and weN are high and addr is zero. refReq and refBusy are both high, because the warm-up burst is outstanding.
- R2: After reset, exactly eight refresh cycles run back to back while the grant is held, with a new RAS fall every 7 clocks. refBusy stays high until the eighth cycle is over. The interval timer does not run during the warm-up burst.
- R3: No strobe moves while busGrant is low. A cycle starts at the clock edge where busGrant and refReq are both high, and its first strobe change is seen one clock after that edge.
- R4: In a CAS-before-RAS cycle (refMode = 0), casN falls one clock before rasN falls. casN stays low for all three RAS-low clocks, then both strobes are high for two precharge clocks, and addr stays zero.
- R5: In a RAS-only cycle (refMode = 1), the row is on addr one clock before rasN falls and stays there for the three RAS-low clocks. casN stays high for the whole cycle. rasN is low for exactly three clocks.
- R6: weN is high throughout every refresh cycle.
- R7: The row counter advances by one after every RAS-only cycle and wraps at 2^12 with the 12/12 split, so addr bit 12 is never set. CAS-before-RAS cycles leave the counter unchanged.
- R8: With the grant held and no backlog, RAS falls are BASE_INTERVAL clocks apart in both modes under the 12/12 split. Under the 13/11 split they are 2*BASE_INTERVAL apart in CAS-before-RAS mode and BASE_INTERVAL apart in RAS-only mode.
- R9: The backlog saturates at PEND_MAX. After the grant has been withheld for many intervals, the run of back-to-back cycles that follows is at least PEND_MAX long. It is longer only by the few timer expiries that fall inside the run itself.
- R10: refReq falls in the same clock that the state returns to idle when no backlog and no warm-up is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 50 MHz nominal |
| rstN | input | 1 | Active-low synchronous reset |
| refMode | input | 1 | 0 = CAS-before-RAS, 1 = RAS-only; sampled when a cycle starts |
| busGrant | input | 1 | Bus handed over by the access sequencer |
| refReq | output | 1 | Request for the memory bus |
| refBusy | output | 1 | Refresh cycle running or warm-up still outstanding |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low; held high |
| addr | output | ADDR_W | Row address during RAS-only refresh, else zero |

## Verification
The strobes are registered behind the state machine, so they lag the state by one clock. If the grant is sampled at edge k, the setup strobe is visible after edge k+1, rasN is low after edges k+2 to k+4, and the strobes are idle again after edge k+5. refBusy and refReq fall after edge k+6. The bench drives the grant on a falling edge and numbers the falling-edge samples from the first rising edge that sees it. Each expected level is tied to a sample index, and back-to-back spacing is fixed at 7 samples. Interval checks measure RAS-fall to RAS-fall distances in steady state. This keeps them free of the timer's unknown phase.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_PRECH} refState_t;

  // strobes handed from control to datapath, one set per clock
  typedef struct packed {
    logic rasLow;
    logic casLow;
    logic rowDrive;
    logic rowAdv;
  } refStrobe_t;
endpackage

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int BASE_INTERVAL = 780,
  parameter int SPLIT13       = 0,
  parameter int RAS_LOW_CYC   = 3,
  parameter int PRE_CYC       = 2,
  parameter int PEND_MAX      = 4,
  parameter int WARM_CNT      = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refMode,
  input  logic       busGrant,
  output refStrobe_t strobe,
  output logic       refReq,
  output logic       refBusy
);
  localparam int LONG_INTERVAL = (SPLIT13 != 0) ? 2 * BASE_INTERVAL : BASE_INTERVAL;
  localparam int TMR_W  = $clog2(LONG_INTERVAL + 1);
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam int WARM_W = $clog2(WARM_CNT + 1);
  localparam int PH_MAX = (RAS_LOW_CYC > PRE_CYC) ? RAS_LOW_CYC : PRE_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  refState_t         state;
  logic [PH_W-1:0]   phase;
  logic [TMR_W-1:0]  tmr;
  logic [TMR_W-1:0]  intervalLast;
  logic [PEND_W-1:0] pendCnt;
  logic [WARM_W-1:0] warmLeft;
  logic              cycRor;
  logic              tick;
  logic              useWarm;
  logic              work;
  logic              start;

  // a 13/11 split with CAS-before-RAS only has to cover half the rows per period
  always_comb begin
    if (SPLIT13 != 0 && !refMode) intervalLast = TMR_W'(LONG_INTERVAL - 1);
    else                          intervalLast = TMR_W'(BASE_INTERVAL - 1);
  end

  assign useWarm = (warmLeft != '0);
  assign tick    = !useWarm && (tmr >= intervalLast);
  assign work    = useWarm || (pendCnt != '0);
  assign start   = (state == ST_IDLE) && work && busGrant;

  always_ff @(posedge clk) begin
    if (!rstN)                tmr <= '0;
    else if (useWarm || tick) tmr <= '0;
    else                      tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendCnt <= '0;
    else begin
      case ({tick, start && !useWarm})
        2'b10:   if (pendCnt < PEND_W'(PEND_MAX)) pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  warmLeft <= WARM_W'(WARM_CNT);
    else if (start && useWarm)  warmLeft <= warmLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      cycRor <= 1'b0;
    else if (start) cycRor <= refMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_SETUP;
        ST_SETUP: begin
          state <= ST_STROBE;
          phase <= '0;
        end
        ST_STROBE: begin
          if (phase == PH_W'(RAS_LOW_CYC - 1)) begin
            state <= ST_PRECH;
            phase <= '0;
          end else phase <= phase + 1'b1;
        end
        default: begin
          if (phase == PH_W'(PRE_CYC - 1)) begin
            state <= ST_IDLE;
            phase <= '0;
          end else phase <= phase + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strobe.rasLow   = (state == ST_STROBE);
    strobe.casLow   = !cycRor && (state == ST_SETUP || state == ST_STROBE);
    strobe.rowDrive =  cycRor && (state == ST_SETUP || state == ST_STROBE);
    strobe.rowAdv   =  cycRor && (state == ST_PRECH) && (phase == PH_W'(PRE_CYC - 1));
  end

  assign refReq  = work || (state != ST_IDLE);
  assign refBusy = useWarm || (state != ST_IDLE);

  // R9: backlog never exceeds its ceiling and grows by at most one per clock
  p_pend_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_W'(PEND_MAX));
  p_pend_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    int'(pendCnt) <= int'($past(pendCnt)) + 1);
  // R3: a cycle only begins after a granted request
  p_grant_needed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETUP) |-> $past(busGrant && refReq));
endmodule

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  refStrobe_t        strobe,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr
);
  logic [ROW_W-1:0] rowCnt;

  // natural wrap at 2^ROW_W
  always_ff @(posedge clk) begin
    if (!rstN)              rowCnt <= '0;
    else if (strobe.rowAdv) rowCnt <= rowCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
      addr <= '0;
    end else begin
      rasN <= !strobe.rasLow;
      casN <= !strobe.casLow;
      weN  <= 1'b1;
      addr <= strobe.rowDrive ? ADDR_W'(rowCnt) : '0;
    end
  end

  // R4: CAS never falls together with RAS
  p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !$fell(casN));
  // R5: RAS low lasts more than one clock
  p_ras_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |=> !rasN);
  // R5: a driven row never comes with CAS low
  p_ror_cas_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && addr != '0) |-> casN);
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refsched_pkg::*;
#(
  parameter int BASE_INTERVAL = 780,
  parameter int SPLIT13       = 0,
  parameter int RAS_LOW_CYC   = 3,
  parameter int PRE_CYC       = 2,
  parameter int PEND_MAX      = 4,
  parameter int WARM_CNT      = 8,
  parameter int ADDR_W        = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refMode,
  input  logic              busGrant,
  output logic              refReq,
  output logic              refBusy,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr
);
  localparam int ROW_W = (SPLIT13 != 0) ? 13 : 12;

  refStrobe_t strobe;

  refsched_ctrl #(
    .BASE_INTERVAL(BASE_INTERVAL), .SPLIT13(SPLIT13), .RAS_LOW_CYC(RAS_LOW_CYC),
    .PRE_CYC(PRE_CYC), .PEND_MAX(PEND_MAX), .WARM_CNT(WARM_CNT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .refMode(refMode), .busGrant(busGrant),
    .strobe(strobe), .refReq(refReq), .refBusy(refBusy)
  );

  refsched_dp #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rasN(rasN), .casN(casN), .weN(weN), .addr(addr)
  );
endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int BASE = 24;
  localparam int PMAX = 4;
  localparam int GAP  = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, refMode, busGrant, refReq, refBusy, rasN, casN, weN;
  logic [12:0] addr;
  logic mode13, grant13, req13, busy13, ras13, cas13, we13;
  logic [12:0] addr13;

  dram_refresh_sched #(.BASE_INTERVAL(BASE), .SPLIT13(0), .PEND_MAX(PMAX)) u_dut (
    .clk(clk), .rstN(rstN), .refMode(refMode), .busGrant(busGrant),
    .refReq(refReq), .refBusy(refBusy), .rasN(rasN), .casN(casN), .weN(weN), .addr(addr));

  dram_refresh_sched #(.BASE_INTERVAL(BASE), .SPLIT13(1), .PEND_MAX(PMAX)) u_dut13 (
    .clk(clk), .rstN(rstN), .refMode(mode13), .busGrant(grant13),
    .refReq(req13), .refBusy(busy13), .rasN(ras13), .casN(cas13), .weN(we13), .addr(addr13));

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // samples until the next RAS fall of the chosen instance; n = samples taken
  task automatic nextFall(input bit onSplit, output int n);
    logic prev;
    prev = onSplit ? ras13 : rasN;
    n = 0;
    while (n < 4000) begin
      @(negedge clk);
      n++;
      if (prev && !(onSplit ? ras13 : rasN)) break;
      prev = onSplit ? ras13 : rasN;
    end
  endtask

  // waits for one refresh cycle on the main instance and checks its shape
  task automatic grabCycle(input bit ror, output int row, output int errs);
    logic pRas, pCas;
    logic [12:0] pAddr;
    int guard;
    errs = 0;
    guard = 0;
    pRas = rasN; pCas = casN; pAddr = addr;
    while (guard < 4000) begin
      @(negedge clk);
      guard++;
      if (pRas && !rasN) break;
      pRas = rasN; pCas = casN; pAddr = addr;
    end
    row = int'(addr);
    if (ror) begin
      if (!(pCas && casN && addr == pAddr && weN)) errs++;
    end else begin
      if (!(!pCas && !casN && addr == 13'd0 && weN)) errs++;
    end
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (rasN || !weN) errs++;
      if (ror && (!casN || addr != pAddr)) errs++;
      if (!ror && (casN || addr != 13'd0)) errs++;
    end
    @(negedge clk);
    if (!rasN || !casN || addr != 13'd0) errs++;
  endtask

  task automatic t_reset();
    rstN = 1'b0; busGrant = 1'b0; refMode = 1'b0; mode13 = 1'b0; grant13 = 1'b0;
    repeat (3) @(negedge clk);
    chk(rasN && casN && weN && addr == 13'd0, "R1 strobes in reset", int'({rasN, casN, weN}), 7);
    rstN = 1'b1;
    grant13 = 1'b1;
    @(negedge clk);
    chk(rasN && casN && weN && addr == 13'd0, "R1 strobes after reset", int'({rasN, casN, weN}), 7);
    chk(refReq && refBusy, "R1 req/busy after reset", int'({refReq, refBusy}), 3);
  endtask

  task automatic t_noGrant();
    int bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!rasN || !casN || !refReq) bad++;
    end
    chk(bad == 0, "R3 no strobe without grant", bad, 0);
  endtask

  task automatic t_warmup();
    int badPat = 0, badBusy = 0, falls = 0;
    logic prev;
    prev = rasN;
    busGrant = 1'b1;
    for (int j = 0; j <= 55; j++) begin
      logic eRas, eCas;
      @(negedge clk);
      eRas = 1'b1; eCas = 1'b1;
      if (j >= 1) begin
        int m = (j - 1) % GAP;
        if (m == 0) eCas = 1'b0;
        if (m >= 1 && m <= 3) begin eRas = 1'b0; eCas = 1'b0; end
      end
      if (rasN != eRas || casN != eCas || addr != 13'd0 || !weN) badPat++;
      if (refBusy != (j <= 54)) badBusy++;
      if (prev && !rasN) falls++;
      prev = rasN;
      if (j == 55) chk(!refReq, "R10 request drops after warm-up", int'(refReq), 0);
    end
    busGrant = 1'b0;
    chk(badPat == 0, "R4 warm-up CAS-before-RAS pattern", badPat, 0);
    chk(badBusy == 0, "R2 busy over warm-up", badBusy, 0);
    chk(falls == 8, "R2 warm-up refresh count", falls, 8);
  endtask

  task automatic t_interval12();
    int n;
    busGrant = 1'b1;
    refMode = 1'b0;
    nextFall(1'b0, n);
    nextFall(1'b0, n);
    nextFall(1'b0, n);
    chk(n == BASE, "R8 12/12 CAS-before-RAS spacing", n, BASE);
    refMode = 1'b1;
    nextFall(1'b0, n);
    nextFall(1'b0, n);
    nextFall(1'b0, n);
    chk(n == BASE, "R8 12/12 RAS-only spacing", n, BASE);
    refMode = 1'b0;
  endtask

  task automatic t_interval13();
    int n;
    mode13 = 1'b0;
    nextFall(1'b1, n);
    nextFall(1'b1, n);
    chk(n == 2 * BASE, "R8 13/11 CAS-before-RAS spacing", n, 2 * BASE);
    mode13 = 1'b1;
    nextFall(1'b1, n);
    nextFall(1'b1, n);
    nextFall(1'b1, n);
    chk(n == BASE, "R8 13/11 RAS-only spacing", n, BASE);
  endtask

  task automatic t_ror();
    int r1, r2, r3, r4, e, errs;
    busGrant = 1'b1;
    refMode = 1'b1;
    errs = 0;
    grabCycle(1'b1, r1, e); errs += e;
    grabCycle(1'b1, r1, e); errs += e;
    grabCycle(1'b1, r2, e); errs += e;
    grabCycle(1'b1, r3, e); errs += e;
    chk(errs == 0, "R5 R6 RAS-only cycle shape", errs, 0);
    chk(r2 == (r1 + 1) % 4096 && r3 == (r2 + 1) % 4096, "R7 row advance", r3, (r1 + 2) % 4096);
    refMode = 1'b0;
    errs = 0;
    for (int i = 0; i < 3; i++) begin
      grabCycle(1'b0, r4, e); errs += e;
    end
    chk(errs == 0, "R4 R6 CAS-before-RAS cycle shape", errs, 0);
    refMode = 1'b1;
    grabCycle(1'b1, r4, e);
    chk(r4 == (r3 + 1) % 4096, "R7 CAS-before-RAS leaves row unchanged", r4, (r3 + 1) % 4096);
  endtask

  task automatic t_sat();
    int n, run, guard;
    guard = 0;
    while (refReq && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    busGrant = 1'b0;
    refMode = 1'b0;
    repeat (12 * BASE) @(negedge clk);
    chk(refReq && rasN, "R3 request held while grant withheld", int'({refReq, rasN}), 3);
    busGrant = 1'b1;
    nextFall(1'b0, n);
    chk(n == 3, "R3 first RAS fall after grant", n, 3);
    run = 1;
    nextFall(1'b0, n);
    while (n == GAP) begin
      run++;
      nextFall(1'b0, n);
    end
    chk(run >= PMAX && run <= PMAX + 3, "R9 saturated backlog run length", run, PMAX);
  endtask

  task automatic t_wrap();
    int r0, prev, r, e, errs, badSeq;
    busGrant = 1'b1;
    refMode = 1'b1;
    errs = 0; badSeq = 0;
    grabCycle(1'b1, r0, e);
    prev = r0;
    for (int i = 0; i < 4096; i++) begin
      grabCycle(1'b1, r, e);
      errs += e;
      if (r != (prev + 1) % 4096 || r > 4095) badSeq++;
      prev = r;
    end
    chk(badSeq == 0, "R7 row sequence over full wrap", badSeq, 0);
    chk(prev == r0, "R7 row wraps at 4096", prev, r0);
    chk(errs == 0, "R5 shape across wrap", errs, 0);
  endtask

  initial begin
    t_reset();
    t_noGrant();
    t_warmup();
    t_interval12();
    t_interval13();
    t_ror();
    t_sat();
    t_wrap();
    report();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end
endmodule